// File: doc/BRIEF.md
# Interpolated Reciprocal Square Root Seed Table

This block supplies the starting estimate for an iterative reciprocal square root unit. The caller forms an 11-bit index from the top eleven fraction bits of a normalised significand in [1, 2). One clock later the block returns a 23-bit fixed-point estimate of 1/sqrt(x), with the binary point just above the most significant bit. The estimate is sampled at the centre of each index interval, so that index a stands for x = 1 + (a + 0.5)/2048.

Only the even-indexed points of the 2048-point curve are kept, plus one guard point at index 2048, so the block holds 1025 words. Odd indices are rebuilt as the mean of the two stored points on either side. The top three bits of each stored point are not kept either. Over the range the estimate lies in [0.707, 1), so its leading bit is constant and the next two bits change at fixed index thresholds. Comparators on the index regenerate those bits, and each stored word is 20 bits wide. All contents are computed at elaboration by a constant function.

Top module: `rsqrt_seed_table`

## Requirements
- R1: While reset is high, and after reset until the first request, seedValid is 0 and seed is 0.
- R2: A request (reqValid high at a rising edge) produces its result on seed and a high seedValid after that same edge. seedValid is low after any edge without a request. Without a request, seed keeps its value and reqAddr has no effect.
- R3: For an even index a, seed equals E(a) = floor(sqrt(2^58 / (4097 + 2a))), which is floor(2^23 / sqrt(1 + (a + 0.5)/2048)).
- R4: For an odd index a, seed equals floor((E(a-1) + E(a+1)) / 2). For a = 2047 this uses E(2048), the guard point.
- R5: For every index a in 0..2047, seed differs from E(a) by at most 1 LSB.
- R6: Bit 22 of every returned seed is 1.
- R7: For an even index, bit 21 of seed is 1 when the index is at most 1592 and 0 otherwise.
- R8: For an even index, bit 20 of seed is 1 when the index is at most 626. Above 626 it is the complement of bit 21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe; the index is taken on this edge |
| reqAddr | input | 11 | Table index: top 11 fraction bits of the significand |
| seedValid | output | 1 | High for the cycle following a request |
| seed | output | 23 | Unsigned estimate of 1/sqrt(x), weight 2^-23 per LSB |

## Verification
The embedded properties check on every cycle that the result strobe follows the request strobe by one edge, that the seed stays put between requests, and that the leading bit is always set. For even indices they also check that the two regenerated bits match the index thresholds. Whether the stored contents, the neighbour selection, the guard point and the averaging are numerically correct can only be seen by the bench. It sweeps all 2048 indices against an integer square-root reference, checking exact values for the even points and the neighbour means, and the 1-LSB bound everywhere. Behaviour of reset in mid-stream and the ignoring of index changes without a request are also covered only by directed bench scenarios.

// File: rtl/rsqrt_seed_pkg.sv
package rsqrt_seed_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new result this edge
    logic interp;  // index is odd: use neighbour mean
  } seedStrobeT;

  // Integer floor square root, bit by bit
  function automatic logic [63:0] sqrtFloor(input logic [63:0] n);
    logic [63:0] r;
    logic [63:0] t;
    r = '0;
    for (int b = 31; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= n) r = t;
    end
    return r;
  endfunction

  // Full-width estimate at interval centre for index a
  function automatic logic [63:0] exactSeed(input int addrW, input int seedW, input int a);
    logic [63:0] num;
    logic [63:0] den;
    num = 64'd1 << (2 * seedW + addrW + 1);
    den = (64'd1 << (addrW + 1)) + 64'd1 + 64'(2 * a);
    return sqrtFloor(num / den);
  endfunction

  // Last index whose estimate is >= 0.75
  function automatic int hiLimit(input int addrW);
    return ((1 << (addrW + 5)) / 9 - ((1 << (addrW + 1)) + 1)) / 2;
  endfunction

  // Last index whose estimate is >= 0.875
  function automatic int midLimit(input int addrW);
    return ((1 << (addrW + 7)) / 49 - ((1 << (addrW + 1)) + 1)) / 2;
  endfunction

endpackage

// File: rtl/rsqrt_seed_rom.sv
module rsqrt_seed_rom #(
  parameter int ADDR_W = 11,
  parameter int SEED_W = 23
) (
  input  logic [ADDR_W-1:0]   idxLo,
  input  logic [ADDR_W-1:0]   idxHi,
  output logic [SEED_W-4:0]   lowLo,
  output logic [SEED_W-4:0]   lowHi
);
  localparam int LOW_W = SEED_W - 3;
  localparam int DEPTH = (1 << (ADDR_W - 1)) + 1;  // even points plus guard

  logic [LOW_W-1:0] romArr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [63:0] FULL = rsqrt_seed_pkg::exactSeed(ADDR_W, SEED_W, 2 * i);
    assign romArr[i] = FULL[LOW_W-1:0];
  end

  assign lowLo = romArr[idxLo];
  assign lowHi = romArr[idxHi];

endmodule

// File: rtl/rsqrt_seed_ctl.sv
module rsqrt_seed_ctl (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reqValid,
  input  logic                       addrLsb,
  output rsqrt_seed_pkg::seedStrobeT strobe,
  output logic                       validQ
);

  always_comb begin
    strobe.load   = reqValid;
    strobe.interp = addrLsb;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= reqValid;
  end

  // R2: result strobe follows the request by one edge
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> validQ);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !validQ);

endmodule

// File: rtl/rsqrt_seed_dp.sv
module rsqrt_seed_dp #(
  parameter int ADDR_W = 11,
  parameter int SEED_W = 23
) (
  input  logic                       clk,
  input  logic                       rst,
  input  rsqrt_seed_pkg::seedStrobeT strobe,
  input  logic [ADDR_W-1:0]          addrIn,
  output logic [SEED_W-1:0]          seedQ
);
  localparam int LOW_W = SEED_W - 3;
  localparam logic [ADDR_W:0] HI_POS  = (ADDR_W + 1)'(rsqrt_seed_pkg::hiLimit(ADDR_W));
  localparam logic [ADDR_W:0] MID_POS = (ADDR_W + 1)'(rsqrt_seed_pkg::midLimit(ADDR_W));

  logic [ADDR_W-1:0] idxLo;
  logic [ADDR_W-1:0] idxHi;
  logic [ADDR_W:0]   posLo;
  logic [ADDR_W:0]   posHi;
  logic [LOW_W-1:0]  lowLo;
  logic [LOW_W-1:0]  lowHi;
  logic [SEED_W-1:0] wordLo;
  logic [SEED_W-1:0] wordHi;
  logic [SEED_W:0]   sumWords;
  logic [SEED_W-1:0] nextSeed;

  // Rebuild the three dropped top bits from the curve position
  function automatic logic [SEED_W-1:0] rebuild(input logic [ADDR_W:0] pos,
                                                input logic [LOW_W-1:0] low);
    logic upper;
    logic middle;
    upper  = (pos <= HI_POS);
    middle = (pos <= MID_POS) ? 1'b1 : ~upper;
    return {1'b1, upper, middle, low};
  endfunction

  always_comb begin
    idxLo = {1'b0, addrIn[ADDR_W-1:1]};
    idxHi = idxLo + 1'b1;
    posLo = {idxLo, 1'b0};
    posHi = {idxHi, 1'b0};
  end

  rsqrt_seed_rom #(.ADDR_W(ADDR_W), .SEED_W(SEED_W)) u_rom (
    .idxLo (idxLo),
    .idxHi (idxHi),
    .lowLo (lowLo),
    .lowHi (lowHi)
  );

  always_comb begin
    wordLo   = rebuild(posLo, lowLo);
    wordHi   = rebuild(posHi, lowHi);
    sumWords = {1'b0, wordLo} + {1'b0, wordHi};
    nextSeed = strobe.interp ? sumWords[SEED_W:1] : wordLo;
  end

  always_ff @(posedge clk) begin
    if (rst)              seedQ <= '0;
    else if (strobe.load) seedQ <= nextSeed;
  end

  // R2: no request, no change
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(seedQ));
  // R6: leading bit always set on a fresh result
  p_msb_set_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> seedQ[SEED_W-1]);
  // R7: second bit against the upper threshold, even indices
  p_even_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !strobe.interp) |=>
      (seedQ[SEED_W-2] == ({1'b0, $past(addrIn)} <= HI_POS)));
  // R8: third bit against the middle threshold, even indices
  p_even_middle_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !strobe.interp) |=>
      (seedQ[SEED_W-3] == (({1'b0, $past(addrIn)} <= MID_POS) ? 1'b1 : ~seedQ[SEED_W-2])));

endmodule

// File: rtl/rsqrt_seed_table.sv
module rsqrt_seed_table #(
  parameter int ADDR_W = 11,
  parameter int SEED_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              seedValid,
  output logic [SEED_W-1:0] seed
);

  rsqrt_seed_pkg::seedStrobeT strobe;

  rsqrt_seed_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .addrLsb  (reqAddr[0]),
    .strobe   (strobe),
    .validQ   (seedValid)
  );

  rsqrt_seed_dp #(.ADDR_W(ADDR_W), .SEED_W(SEED_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .addrIn (reqAddr),
    .seedQ  (seed)
  );

endmodule

// File: tb/rsqrt_seed_table_tb.sv
`timescale 1ns/1ps
module rsqrt_seed_table_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [10:0] reqAddr = '0;
  logic        seedValid;
  logic [22:0] seed;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rsqrt_seed_table u_dut (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .seedValid (seedValid),
    .seed      (seed)
  );

  // Index and expected top three bits (R6, R7, R8), even indices
  localparam logic [13:0] VECS [0:9] = '{
    {11'd0,    3'b111}, {11'd2,    3'b111}, {11'd624,  3'b111}, {11'd626,  3'b111},
    {11'd628,  3'b110}, {11'd1000, 3'b110}, {11'd1592, 3'b110}, {11'd1594, 3'b101},
    {11'd1800, 3'b101}, {11'd2046, 3'b101}
  };

  // Reference: floor sqrt by integer Newton iteration
  function automatic longint unsigned isqrtRef(input longint unsigned n);
    longint unsigned x;
    longint unsigned y;
    if (n < 2) return n;
    x = n;
    y = (x + 1) / 2;
    while (y < x) begin
      x = y;
      y = (x + n / x) / 2;
    end
    return x;
  endfunction

  function automatic longint unsigned exactRef(input int a);
    longint unsigned num;
    num = 64'd1 << 58;
    return isqrtRef(num / longint'(4097 + 2 * a));
  endfunction

  function automatic longint unsigned expectRef(input int a);
    if (a % 2 == 0) return exactRef(a);
    return (exactRef(a - 1) + exactRef(a + 1)) / 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // One request, result sampled on the following falling edge
  task automatic doReq(input int a);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = 11'(a);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [22:0] held;
    longint      diff;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(seedValid == 1'b0, "R1 valid in reset", seedValid, 0);
    chk(seed == 23'd0, "R1 seed in reset", seed, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(seedValid == 1'b0, "R1 valid before request", seedValid, 0);
    chk(seed == 23'd0, "R1 seed before request", seed, 0);

    // Vector table: top-bit rebuild on even indices
    for (int i = 0; i < 10; i++) begin
      doReq(int'(VECS[i][13:3]));
      chk(seed[22:20] == VECS[i][2:0], "R7/R8 top bits", seed[22:20], VECS[i][2:0]);
      chk(seed[21] == (VECS[i][13:3] <= 11'd1592), "R7 upper bit", seed[21], VECS[i][1]);
      chk(seed[20] == VECS[i][0], "R8 middle bit", seed[20], VECS[i][0]);
    end

    // Full sweep of all indices
    for (int a = 0; a < 2048; a++) begin
      doReq(a);
      chk(seedValid == 1'b1, "R2 valid after request", seedValid, 1);
      chk(seed[22] == 1'b1, "R6 leading bit", seed[22], 1);
      if (a % 2 == 0)
        chk(longint'(seed) == longint'(exactRef(a)), "R3 even point", seed, exactRef(a));
      else
        chk(longint'(seed) == longint'(expectRef(a)), "R4 odd mean", seed, expectRef(a));
      diff = longint'(seed) - longint'(exactRef(a));
      chk(diff <= 1 && diff >= -1, "R5 within 1 LSB", seed, exactRef(a));
    end

    // R4: last odd index uses the guard point
    doReq(2047);
    chk(longint'(seed) == longint'((exactRef(2046) + exactRef(2048)) / 2),
        "R4 last odd index", seed, (exactRef(2046) + exactRef(2048)) / 2);

    // R2: idle cycles ignore index changes and hold the result
    doReq(700);
    held = seed;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      reqAddr = 11'(37 + 300 * k);
      @(negedge clk);
      chk(seed == held, "R2 hold without request", seed, held);
      chk(seedValid == 1'b0, "R2 valid low when idle", seedValid, 0);
    end

    // R2: back-to-back requests
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = 11'd100;
    @(negedge clk);
    chk(seedValid == 1'b1, "R2 first of pair valid", seedValid, 1);
    chk(longint'(seed) == longint'(expectRef(100)), "R2 first of pair", seed, expectRef(100));
    reqAddr = 11'd1999;
    @(negedge clk);
    reqValid = 1'b0;
    chk(seedValid == 1'b1, "R2 second of pair valid", seedValid, 1);
    chk(longint'(seed) == longint'(expectRef(1999)), "R2 second of pair", seed, expectRef(1999));
    @(negedge clk);
    chk(seedValid == 1'b0, "R2 valid drops", seedValid, 0);

    // R1: reset in mid-stream clears outputs
    doReq(5);
    rst = 1'b1;
    @(negedge clk);
    chk(seedValid == 1'b0, "R1 valid after mid reset", seedValid, 0);
    chk(seed == 23'd0, "R1 seed after mid reset", seed, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(seed == 23'd0, "R1 seed stays clear", seed, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule